// File: doc/BRIEF.md
# Interrupt Slot Range Allocator

The block tracks which of a fixed pool of interrupt slots are taken and serves allocation and release requests against that pool. A requester can claim one named slot, claim the lowest free slot, or claim a run of consecutive free slots. A run can be placed anywhere, or only at starts that are a multiple of its length. Each slot handed out is tagged as level-type or message-type. Slot numbers seen at the ports are the slot index plus a fixed base number.

Requests use a valid/ready handshake. Named-slot claims, releases and rejected requests complete in the cycle after acceptance. Searches walk the pool one slot per clock, starting at candidate position 0 and stepping by the alignment stride, and stop as soon as too few slots remain. Every request ends in a one-cycle `done_o` pulse carrying a fail flag, a warning flag and the resulting number. A side lookup port reads back the state and type of any slot.

Top module: `irq_alloc`

## Requirements
- R1: After reset every slot reads free with type 0, `req_ready_o` is 1 and `done_o` is 0.
- R2: A named claim (`req_op_i`=0) with number h in [BASE, BASE+NUM_SLOTS) whose slot is free marks exactly that slot and returns h. If the slot is taken, or h is outside that range, it fails and leaves the pool unchanged.
- R3: A lowest-free claim (`req_op_i`=1) returns the lowest-numbered free slot.
- R4: An unaligned run claim (`req_op_i`=2, `req_align_i`=0) of length n returns the lowest start s for which slots s..s+n-1 are all free, and marks all n slots.
- R5: An aligned run claim (`req_op_i`=2, `req_align_i`=1) only considers starts that are multiples of n. It accepts only n in {1,2,4,8,16,32}, and any other n fails in the cycle after acceptance without searching.
- R6: A run claim fails when n is 0 or greater than NUM_SLOTS. A search fails as soon as the slots from the current candidate start to the end of the pool number fewer than n.
- R7: Every successful claim returns slot index plus BASE on `id_o`.
- R8: Each claimed slot records `req_lvl_i` (1 = level, 0 = message), readable on `look_lvl_o` for the slot at `look_idx_i`. A released slot reads type 0.
- R9: A release (`req_op_i`=3) of n slots from number h frees every slot in the range and raises `warn_o` when any of them was already free. If n is 0 or the range leaves the pool, it fails and changes nothing.
- R10: A search spends one clock per slot examined, plus one clock when it fails because too few slots remain. `done_o` rises k clocks after the accepting edge, where k is that clock count. Named claims, releases and rejected requests give `done_o` directly after the accepting edge. `req_ready_o` is 0 while a search runs, and requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 2 | 0 named claim, 1 lowest free, 2 run claim, 3 release |
| req_id_i | input | ID_W | Named slot number, or first number to release |
| req_num_i | input | NUM_W | Run or release length |
| req_align_i | input | 1 | Run claim must start at a multiple of its length |
| req_lvl_i | input | 1 | Type tag for claimed slots: 1 level, 0 message |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Request failed, valid with done_o |
| warn_o | output | 1 | Release touched an already free slot, valid with done_o |
| id_o | output | ID_W | Resulting number, meaningful with done_o and not fail_o |
| look_idx_i | input | IDX_W | Slot index to inspect |
| look_used_o | output | 1 | Inspected slot is taken |
| look_lvl_o | output | 1 | Type tag of inspected slot |

## Verification
The bench builds the block with 16 slots and a base of 32, so a handful of requests can fill the whole pool. It can then reach the exhaustion cases: a lowest-free search on a full pool that walks all 16 slots before failing, and an aligned search that runs past the end. With a 6-bit length field it can also ask for a length of 17, which is over the pool size, and for a non-power-of-two aligned length. Search latencies are counted in clocks against hand-computed walks over a partly filled pool.

// File: rtl/irq_alloc_pkg.sv
package irq_alloc_pkg;
  typedef enum logic [1:0] {
    OP_HINT  = 2'd0,
    OP_FIRST = 2'd1,
    OP_BLOCK = 2'd2,
    OP_FREE  = 2'd3
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } st_e;

  localparam int unsigned MAX_ALIGN = 32;
endpackage

// File: rtl/irq_alloc_decode.sv
module irq_alloc_decode
  import irq_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned BASE      = 4096,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned NUM_W     = 7
) (
  input  op_e              op_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             align_i,
  output logic [NUM_W-1:0] rel_o,
  output logic             hint_ok_o,
  output logic             blk_ok_o,
  output logic             free_ok_o,
  output logic [NUM_W-1:0] eff_num_o,
  output logic [NUM_W-1:0] stride_o
);
  logic [ID_W:0] rel_w, end_w;
  logic          below, pow2, num_nz;

  assign below  = id_i < ID_W'(BASE);
  assign rel_w  = {1'b0, id_i} - (ID_W+1)'(BASE);
  assign end_w  = rel_w + (ID_W+1)'(num_i);
  assign rel_o  = NUM_W'(rel_w);
  assign num_nz = num_i != '0;
  assign pow2   = (num_i & (num_i - NUM_W'(1))) == '0;

  assign hint_ok_o = !below && (rel_w < (ID_W+1)'(NUM_SLOTS));
  assign free_ok_o = hint_ok_o && num_nz && (end_w <= (ID_W+1)'(NUM_SLOTS));

  always_comb begin
    if (op_i == OP_FIRST) begin
      blk_ok_o  = 1'b1;
      eff_num_o = NUM_W'(1);
      stride_o  = NUM_W'(1);
    end else begin
      blk_ok_o  = num_nz && (num_i <= NUM_W'(NUM_SLOTS)) &&
                  (!align_i || (pow2 && (num_i <= NUM_W'(MAX_ALIGN))));
      eff_num_o = num_i;
      stride_o  = align_i ? num_i : NUM_W'(1);
    end
  end
endmodule

// File: rtl/irq_alloc_map.sv
module irq_alloc_map #(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned NUM_W     = 7,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_set_i,
  input  logic             wr_lvl_i,
  input  logic [NUM_W-1:0] wr_start_i,
  input  logic [NUM_W-1:0] wr_num_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_used_o,
  output logic             hole_o,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             look_used_o,
  output logic             look_lvl_o
);
  logic [NUM_SLOTS-1:0] used_q, used_d, lvl_q, lvl_d, in_rng;
  logic [NUM_W:0]       stop;

  assign stop = {1'b0, wr_start_i} + {1'b0, wr_num_i};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [NUM_W:0] POS = (NUM_W+1)'(i);
    assign in_rng[i] = ({1'b0, wr_start_i} <= POS) && (POS < stop);
  end

  always_comb begin
    used_d = used_q;
    lvl_d  = lvl_q;
    if (wr_en_i) begin
      if (wr_set_i) begin
        used_d = used_q | in_rng;
        lvl_d  = (lvl_q & ~in_rng) | (in_rng & {NUM_SLOTS{wr_lvl_i}});
      end else begin
        used_d = used_q & ~in_rng;
        lvl_d  = lvl_q & ~in_rng;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      lvl_q  <= '0;
    end else begin
      used_q <= used_d;
      lvl_q  <= lvl_d;
    end
  end

  assign rd_used_o   = used_q[rd_idx_i];
  assign hole_o      = |(in_rng & ~used_q);
  assign look_used_o = used_q[look_idx_i];
  assign look_lvl_o  = lvl_q[look_idx_i];

  // R4: a claim marks its whole range
  a_r4_set_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_set_i) |=> ((used_q & $past(in_rng)) == $past(in_rng)));
  // R9: a release leaves its range free and untyped
  a_r9_clear_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_set_i) |=> (((used_q | lvl_q) & $past(in_rng)) == '0));
endmodule

// File: rtl/irq_alloc_ctrl.sv
module irq_alloc_ctrl
  import irq_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned BASE      = 4096,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned NUM_W     = 7,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  op_e              op_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             lvl_i,
  input  logic [NUM_W-1:0] rel_i,
  input  logic             hint_ok_i,
  input  logic             blk_ok_i,
  input  logic             free_ok_i,
  input  logic [NUM_W-1:0] eff_num_i,
  input  logic [NUM_W-1:0] stride_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             rd_used_i,
  input  logic             hole_i,
  output logic             wr_en_o,
  output logic             wr_set_o,
  output logic             wr_lvl_o,
  output logic [NUM_W-1:0] wr_start_o,
  output logic [NUM_W-1:0] wr_num_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             warn_o,
  output logic [ID_W-1:0]  id_o
);
  st_e              state_q, state_d;
  logic [NUM_W-1:0] start_q, start_d, pos_q, pos_d;
  logic [NUM_W-1:0] num_q, num_d, stride_q, stride_d;
  logic             lvl_q, lvl_d;
  logic [NUM_W-1:0] cur, room;
  logic             rsp_v, rsp_fail, rsp_warn;
  logic [ID_W-1:0]  rsp_id;

  assign cur         = start_q + pos_q;
  assign room        = NUM_W'(NUM_SLOTS) - start_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_idx_o    = (state_q == ST_SCAN) ? cur[IDX_W-1:0] : rel_i[IDX_W-1:0];

  always_comb begin
    state_d    = state_q;
    start_d    = start_q;
    pos_d      = pos_q;
    num_d      = num_q;
    stride_d   = stride_q;
    lvl_d      = lvl_q;
    wr_en_o    = 1'b0;
    wr_set_o   = 1'b1;
    wr_lvl_o   = lvl_i;
    wr_start_o = rel_i;
    wr_num_o   = NUM_W'(1);
    rsp_v      = 1'b0;
    rsp_fail   = 1'b0;
    rsp_warn   = 1'b0;
    rsp_id     = id_i;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          unique case (op_i)
            OP_HINT: begin
              rsp_v = 1'b1;
              if (!hint_ok_i || rd_used_i) rsp_fail = 1'b1;
              else wr_en_o = 1'b1;
            end
            OP_FIRST, OP_BLOCK: begin
              if (!blk_ok_i) begin
                rsp_v    = 1'b1;
                rsp_fail = 1'b1;
              end else begin
                state_d  = ST_SCAN;
                start_d  = '0;
                pos_d    = '0;
                num_d    = eff_num_i;
                stride_d = stride_i;
                lvl_d    = lvl_i;
              end
            end
            OP_FREE: begin
              rsp_v = 1'b1;
              if (!free_ok_i) begin
                rsp_fail = 1'b1;
              end else begin
                wr_en_o  = 1'b1;
                wr_set_o = 1'b0;
                wr_num_o = num_i;
                rsp_warn = hole_i;
              end
            end
            default: ;
          endcase
        end
      end
      ST_SCAN: begin
        wr_start_o = start_q;
        wr_num_o   = num_q;
        wr_lvl_o   = lvl_q;
        rsp_id     = ID_W'(BASE) + ID_W'(start_q);
        if ((pos_q == '0) && (num_q > room)) begin
          rsp_v    = 1'b1;
          rsp_fail = 1'b1;
          state_d  = ST_IDLE;
        end else if (rd_used_i) begin
          start_d = start_q + stride_q;
          pos_d   = '0;
        end else if (pos_q == num_q - NUM_W'(1)) begin
          wr_en_o = 1'b1;
          rsp_v   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          pos_d = pos_q + NUM_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      start_q  <= '0;
      pos_q    <= '0;
      num_q    <= NUM_W'(1);
      stride_q <= NUM_W'(1);
      lvl_q    <= 1'b0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
      warn_o   <= 1'b0;
      id_o     <= '0;
    end else begin
      state_q  <= state_d;
      start_q  <= start_d;
      pos_q    <= pos_d;
      num_q    <= num_d;
      stride_q <= stride_d;
      lvl_q    <= lvl_d;
      done_o   <= rsp_v;
      fail_o   <= rsp_v && rsp_fail;
      warn_o   <= rsp_v && rsp_warn;
      if (rsp_v) id_o <= rsp_id;
    end
  end

  // R5: candidate starts stay on the stride grid
  a_r5_aligned_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |-> ((start_q & (stride_q - NUM_W'(1))) == '0));
  // R6: the walk never passes the end of the pool
  a_r6_start_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |-> (start_q <= NUM_W'(NUM_SLOTS)));
  // R7: successful numbers lie in the pool window
  a_r7_id_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> ((id_o >= ID_W'(BASE)) && (id_o < ID_W'(BASE + NUM_SLOTS))));
  // R9: a warning comes only with a successful completion
  a_r9_warn_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> (done_o && !fail_o));
endmodule

// File: rtl/irq_alloc.sv
module irq_alloc
  import irq_alloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned BASE      = 4096,
  parameter int unsigned ID_W      = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned NUM_W    = ($clog2(NUM_SLOTS + 1) > 6) ? $clog2(NUM_SLOTS + 1) : 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [NUM_W-1:0] req_num_i,
  input  logic             req_align_i,
  input  logic             req_lvl_i,
  output logic             done_o,
  output logic             fail_o,
  output logic             warn_o,
  output logic [ID_W-1:0]  id_o,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             look_used_o,
  output logic             look_lvl_o
);
  op_e              op;
  logic [NUM_W-1:0] rel, eff_num, stride, wr_start, wr_num;
  logic             hint_ok, blk_ok, free_ok;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_used, hole, wr_en, wr_set, wr_lvl;

  assign op = op_e'(req_op_i);

  irq_alloc_decode #(
    .NUM_SLOTS(NUM_SLOTS), .BASE(BASE), .ID_W(ID_W), .NUM_W(NUM_W)
  ) u_decode (
    .op_i      (op),
    .id_i      (req_id_i),
    .num_i     (req_num_i),
    .align_i   (req_align_i),
    .rel_o     (rel),
    .hint_ok_o (hint_ok),
    .blk_ok_o  (blk_ok),
    .free_ok_o (free_ok),
    .eff_num_o (eff_num),
    .stride_o  (stride)
  );

  irq_alloc_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .BASE(BASE), .ID_W(ID_W), .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .op_i        (op),
    .id_i        (req_id_i),
    .num_i       (req_num_i),
    .lvl_i       (req_lvl_i),
    .rel_i       (rel),
    .hint_ok_i   (hint_ok),
    .blk_ok_i    (blk_ok),
    .free_ok_i   (free_ok),
    .eff_num_i   (eff_num),
    .stride_i    (stride),
    .rd_idx_o    (rd_idx),
    .rd_used_i   (rd_used),
    .hole_i      (hole),
    .wr_en_o     (wr_en),
    .wr_set_o    (wr_set),
    .wr_lvl_o    (wr_lvl),
    .wr_start_o  (wr_start),
    .wr_num_o    (wr_num),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .warn_o      (warn_o),
    .id_o        (id_o)
  );

  irq_alloc_map #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_set_i    (wr_set),
    .wr_lvl_i    (wr_lvl),
    .wr_start_i  (wr_start),
    .wr_num_i    (wr_num),
    .rd_idx_i    (rd_idx),
    .rd_used_o   (rd_used),
    .hole_o      (hole),
    .look_idx_i  (look_idx_i),
    .look_used_o (look_used_o),
    .look_lvl_o  (look_lvl_o)
  );
endmodule

// File: tb/irq_alloc_bench.sv
module irq_alloc_bench;
  localparam int N     = 16;
  localparam int B     = 32;
  localparam int ID_W  = 16;
  localparam int IDX_W = 4;
  localparam int NUM_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic             ready;
  logic [1:0]       op = 2'd0;
  logic [ID_W-1:0]  rid = '0;
  logic [NUM_W-1:0] num = '0;
  logic             align = 1'b0;
  logic             lvl = 1'b0;
  logic             done, fail, warn;
  logic [ID_W-1:0]  id;
  logic [IDX_W-1:0] look_idx = '0;
  logic             look_used, look_lvl;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_alloc #(.NUM_SLOTS(N), .BASE(B), .ID_W(ID_W)) u_irq_alloc (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(op), .req_id_i(rid), .req_num_i(num),
    .req_align_i(align), .req_lvl_i(lvl),
    .done_o(done), .fail_o(fail), .warn_o(warn), .id_o(id),
    .look_idx_i(look_idx), .look_used_o(look_used), .look_lvl_o(look_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic peek(input int idx, output int u, output int l);
    look_idx = idx[IDX_W-1:0];
    #1;
    u = int'(look_used);
    l = int'(look_lvl);
  endtask

  // issue one request, wait for done; lat = clocks after the accepting edge
  task automatic req(input int o, input int h, input int n, input logic al, input logic lv,
                     output int f, output int w, output int r, output int lat);
    @(negedge clk);
    valid = 1'b1; op = o[1:0]; rid = h[ID_W-1:0]; num = n[NUM_W-1:0];
    align = al; lvl = lv;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    f = int'(fail); w = int'(warn); r = int'(id);
  endtask

  task automatic t_reset;
    int u, l;
    chk("R1 ready", int'(ready), 1);
    chk("R1 done", int'(done), 0);
    for (int i = 0; i < N; i++) begin
      peek(i, u, l);
      chk("R1 slot free", u + l, 0);
    end
  endtask

  task automatic t_hint;
    int f, w, r, lat, u, l;
    req(0, B + 5, 1, 1'b0, 1'b1, f, w, r, lat);
    chk("R2 hint ok", f, 0);
    chk("R7 hint id", r, B + 5);
    chk("R10 hint lat", lat, 0);
    peek(5, u, l);
    chk("R2 slot5 used", u, 1);
    chk("R8 slot5 level", l, 1);
    peek(4, u, l);
    chk("R2 slot4 untouched", u, 0);
    req(0, B + 5, 1, 1'b0, 1'b0, f, w, r, lat);
    chk("R2 hint busy fails", f, 1);
    peek(5, u, l);
    chk("R2 busy keeps type", l, 1);
    req(0, B + N, 1, 1'b0, 1'b0, f, w, r, lat);
    chk("R2 hint above fails", f, 1);
    req(0, B - 1, 1, 1'b0, 1'b0, f, w, r, lat);
    chk("R2 hint below fails", f, 1);
    peek(15, u, l);
    chk("R2 no stray write", u, 0);
  endtask

  task automatic t_first;
    int f, w, r, lat, u, l;
    req(1, 0, 0, 1'b0, 1'b0, f, w, r, lat);
    chk("R3 first ok", f, 0);
    chk("R3 first id", r, B);
    chk("R10 first lat", lat, 1);
    req(1, 0, 0, 1'b0, 1'b1, f, w, r, lat);
    chk("R3 second id", r, B + 1);
    chk("R10 second lat", lat, 2);
    peek(1, u, l);
    chk("R8 slot1 level", l, 1);
    peek(0, u, l);
    chk("R8 slot0 message", l, 0);
  endtask

  task automatic t_block;
    int f, w, r, lat, u, l;
    // pool holds 0,1,5
    req(2, 0, 3, 1'b0, 1'b0, f, w, r, lat);
    chk("R4 run3 id", r, B + 2);
    chk("R10 run3 lat", lat, 5);
    req(2, 0, 4, 1'b1, 1'b1, f, w, r, lat);
    chk("R5 aligned4 id", r, B + 8);
    chk("R10 aligned4 lat", lat, 6);
    peek(8, u, l);
    chk("R8 slot8 level", l, 1);
    peek(11, u, l);
    chk("R5 slot11 used", u, 1);
    peek(12, u, l);
    chk("R5 slot12 free", u, 0);
    req(2, 0, 4, 1'b0, 1'b0, f, w, r, lat);
    chk("R4 run4 skips holes", r, B + 12);
    req(2, 0, 3, 1'b1, 1'b0, f, w, r, lat);
    chk("R5 aligned3 fails", f, 1);
    chk("R5 aligned3 lat", lat, 0);
    req(2, 0, 2, 1'b1, 1'b1, f, w, r, lat);
    chk("R5 aligned2 id", r, B + 6);
    chk("R10 aligned2 lat", lat, 5);
    // pool now full
    req(2, 0, 0, 1'b0, 1'b0, f, w, r, lat);
    chk("R6 zero len fails", f, 1);
    chk("R6 zero len lat", lat, 0);
    req(2, 0, N + 1, 1'b0, 1'b0, f, w, r, lat);
    chk("R6 oversize fails", f, 1);
    req(1, 0, 0, 1'b0, 1'b0, f, w, r, lat);
    chk("R6 full first fails", f, 1);
    chk("R10 full first lat", lat, N + 1);
    req(2, 0, 8, 1'b1, 1'b0, f, w, r, lat);
    chk("R6 full aligned8 fails", f, 1);
    chk("R10 full aligned8 lat", lat, 3);
  endtask

  task automatic t_free;
    int f, w, r, lat, u, l;
    req(3, B + 6, 2, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 free ok", f, 0);
    chk("R9 free no warn", w, 0);
    chk("R10 free lat", lat, 0);
    peek(6, u, l);
    chk("R9 slot6 free", u, 0);
    chk("R8 slot6 type cleared", l, 0);
    req(3, B + 6, 3, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 refree warns", w, 1);
    peek(8, u, l);
    chk("R9 slot8 freed", u, 0);
    req(3, B + 14, 3, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 overrun fails", f, 1);
    peek(14, u, l);
    chk("R9 overrun no change", u, 1);
    req(3, B + 9, 0, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 zero len fails", f, 1);
    req(3, B - 1, 1, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 below base fails", f, 1);
    req(1, 0, 0, 1'b0, 1'b0, f, w, r, lat);
    chk("R3 refill lowest", r, B + 6);
  endtask

  task automatic t_busy;
    int f, w, r, lat, u, l;
    req(3, B, N, 1'b0, 1'b0, f, w, r, lat);
    chk("R9 free all warns", w, 1);
    @(negedge clk);
    valid = 1'b1; op = 2'd2; rid = '0; num = 6'd8; align = 1'b0; lvl = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op = 2'd1;
    lat = 0;
    repeat (2) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 ready low in scan", int'(ready), 0);
    chk("R10 no done mid scan", int'(done), 0);
    valid = 1'b0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 run8 lat", lat, 8);
    chk("R4 run8 id", int'(id), B);
    @(negedge clk);
    peek(8, u, l);
    chk("R10 ignored request", u, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hint();
    t_first();
    t_block();
    t_free();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule